// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked system use an external asynchronous static RAM of 131,072 words by 8 bits. A client issues one single-word read or write at a time through a valid/write/address/data request port. The controller turns each request into a sequence of active-low strobes (chip select, write strobe, output enable). It drives the 17-bit address and a tri-state 8-bit data bus. For reads it hands back the captured word together with a one-cycle completion pulse.

The length of the access window comes from two parameters. One is the clock period in picoseconds. The other is a speed-grade index, for a memory whose address access time equals its cycle time. The strobes follow a fixed order. The data bus is driven only while the memory outputs are off. The data stays driven past the rising edge of the write strobe. Every access ends with a cycle in which all strobes are deasserted. Between requests the memory is kept in standby with chip select high.

Top module: `asram_ctl`

## Requirements
- R1: During reset, and in the cycle after any clock edge at which reset is high, mem_ce_n, mem_we_n and mem_oe_n are 1, the data bus is released, ready is 1 and done is 0. This also holds when reset arrives in the middle of an access.
- R2: Whenever ready is 1 the memory is in standby: mem_ce_n, mem_we_n and mem_oe_n are 1 and the controller does not drive mem_dq.
- R3: A request is taken only at a clock edge where req_valid and ready are both 1. ready falls in the next cycle, and a req_valid raised while ready is 0 has no effect on the memory or on done.
- R4: In the first cycle after acceptance, mem_addr carries the request address with all three strobes high. A write then holds mem_ce_n and mem_we_n low with mem_oe_n kept high throughout.
- R5: During a write, mem_dq carries the request data in every cycle mem_we_n is low. It still carries that data in the one cycle after mem_we_n rises, with mem_ce_n still low, and is released on the following edge.
- R6: A word is committed to the memory on the rising edge of mem_we_n, so that a later read of the same address returns it.
- R7: A read holds mem_ce_n and mem_oe_n low with mem_we_n high, and the controller never drives mem_dq while mem_oe_n is low.
- R8: At the end of a read, rdata holds the word on mem_dq and done is 1 for exactly one cycle. rdata keeps its value until the next read completes, and writes leave it unchanged.
- R9: The strobe-active window lasts W cycles, where W = max(1, ceil(T*1000/CLK_PS)). T is the access time in ns picked by GRADE (0:8, 1:10, 2:12, 3:15, 4 and above:20). With the defaults (GRADE=2, CLK_PS=10000) W=2. done therefore appears W+2 cycles after acceptance for a read and W+3 for a write.
- R10: done comes in a cycle with all strobes high and ready still 0. ready rises only in the cycle after done, so any two accesses are separated by at least one cycle with all strobes deasserted.
- R11: mem_addr does not change while mem_ce_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle, can take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last word read |
| mem_addr | output | 17 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | inout | 8 | Bidirectional data bus |

## Verification
The assertions assume that reset is held for at least two clock edges. They also assume that the attached memory drives mem_dq only while its chip select and output enable are low and its write strobe is high. The bench's memory model obeys exactly that rule and commits data only on a rising write strobe with chip select low. Each test address has its own distinct low address byte, because the model keys its storage on that byte. Requests are presented only after ready is seen high. The one exception is a deliberate pulse of req_valid during a busy access, which tests that such a request is ignored.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_WREL,
    ST_REC
  } seq_state_t;

  // access time in ns for a speed-grade index (access == cycle time)
  function automatic int unsigned grade_ns(int unsigned g);
    case (g)
      0:       return 8;
      1:       return 10;
      2:       return 12;
      3:       return 15;
      default: return 20;
    endcase
  endfunction

  function automatic int unsigned wait_cycles(int unsigned g, int unsigned clk_ps);
    int unsigned t_ps;
    int unsigned w;
    t_ps = grade_ns(g) * 1000;
    w    = (t_ps + clk_ps - 1) / clk_ps;
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/sbr_wait_timer.sv
module sbr_wait_timer #(
  parameter int unsigned COUNT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  output logic expired
);
  localparam int unsigned CW = (COUNT < 2) ? 1 : $clog2(COUNT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= CW'(COUNT - 1);
    else if (en && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sbr_seq.sv
module sbr_seq
  import sbr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic expired,
  output logic accept,
  output logic tmr_load,
  output logic tmr_en,
  output logic capture,
  output logic ready,
  output logic done,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);
  seq_state_t state, nxt;
  logic       op_wr, op_wr_nxt;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign tmr_load  = (state == ST_SETUP);
  assign tmr_en    = (state == ST_ACT);
  assign capture   = (state == ST_ACT) && expired && !op_wr;
  assign op_wr_nxt = accept ? req_write : op_wr;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (req_valid) nxt = ST_SETUP;
      ST_SETUP: nxt = ST_ACT;
      ST_ACT:   if (expired) nxt = op_wr ? ST_WREL : ST_REC;
      ST_WREL:  nxt = ST_REC;
      ST_REC:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  // outputs registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      op_wr <= 1'b0;
      ready <= 1'b1;
      done  <= 1'b0;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      state <= nxt;
      op_wr <= op_wr_nxt;
      ready <= (nxt == ST_IDLE);
      done  <= (nxt == ST_REC);
      ce_n  <= !((nxt == ST_ACT) || (nxt == ST_WREL));
      we_n  <= !((nxt == ST_ACT) && op_wr_nxt);
      oe_n  <= !((nxt == ST_ACT) && !op_wr_nxt);
      dq_oe <= ((nxt == ST_ACT) || (nxt == ST_WREL)) && op_wr_nxt;
    end
  end
endmodule

// File: rtl/sbr_datapath.sv
module sbr_datapath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        dq_out   <= req_wdata;
      end
      if (capture)
        rdata <= dq_in;
    end
  end
endmodule

// File: rtl/asram_ctl.sv
module asram_ctl #(
  parameter int unsigned CLK_PS = 10000,
  parameter int unsigned GRADE  = 2,
  parameter int unsigned AW     = 17,
  parameter int unsigned DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  inout  wire  [DW-1:0] mem_dq
);
  localparam int unsigned WAITS = sbr_pkg::wait_cycles(GRADE, CLK_PS);

  logic          accept, tmr_load, tmr_en, capture, expired, dq_oe;
  logic [DW-1:0] dq_out;
  logic [DW-1:0] dq_in;

  sbr_wait_timer #(.COUNT(WAITS)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .en(tmr_en), .expired(expired)
  );

  sbr_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .expired(expired), .accept(accept), .tmr_load(tmr_load), .tmr_en(tmr_en),
    .capture(capture), .ready(ready), .done(done), .ce_n(mem_ce_n),
    .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(dq_oe)
  );

  sbr_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(dq_in),
    .mem_addr(mem_addr), .dq_out(dq_out), .rdata(rdata)
  );

  assign mem_dq = dq_oe ? dq_out : {DW{1'bz}};
  assign dq_in  = mem_dq;
endmodule

// File: rtl/sbr_chk.sv
module sbr_chk #(
  parameter int unsigned WAITS = 2,
  parameter int unsigned AW    = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          done,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [AW-1:0] addr
);
  logic        rst_q;
  logic [31:0] we_low_cnt;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)        we_low_cnt <= '0;
    else if (!we_n) we_low_cnt <= we_low_cnt + 1;
    else            we_low_cnt <= '0;
  end

  // R1: outputs idle one cycle after reset was sampled
  always @(posedge clk) begin
    if (rst_q)
      assert_reset_idle_R1: assert (ce_n && we_n && oe_n && !dq_oe && ready && !done)
        else $error("reset state not idle");
  end

  assert_standby_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ce_n && we_n && oe_n && !dq_oe));

  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (oe_n && !ce_n));

  assert_drive_past_we_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (dq_oe && !ce_n));

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && we_n) |=> !dq_oe);

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (!dq_oe && we_n && !ce_n));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_wait_len_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (we_low_cnt == WAITS));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (ce_n && we_n && oe_n && !ready));

  assert_ready_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(done));

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !$past(ce_n)) |-> $stable(addr));
endmodule

bind asram_ctl sbr_chk #(.WAITS(WAITS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .done(done), .ce_n(mem_ce_n),
  .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(dq_oe), .addr(mem_addr)
);

// File: tb/sim_asram_ctl.sv
module sim_asram_ctl;
  localparam int BW = (12000 + 10000 - 1) / 10000; // R9: grade 2 at 10 ns -> 2
  localparam int NV = 10;
  // {write, addr[16:0], data[7:0], expected read[7:0]}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 17'h00000, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h5A, 8'h00},
    {1'b1, 17'h0A1B2, 8'h3C, 8'h00},
    {1'b1, 17'h12345, 8'h00, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h5A},
    {1'b1, 17'h0A1B2, 8'hC3, 8'h00},
    {1'b0, 17'h0A1B2, 8'h00, 8'hC3},
    {1'b0, 17'h12345, 8'h00, 8'h00},
    {1'b0, 17'h0A1B2, 8'h00, 8'hC3}
  };

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, done, ce_n, we_n, oe_n;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  wire  [7:0]  dq;
  logic [7:0]  model [256];
  int          nchk = 0, nbad = 0;
  logic [7:0]  last_rd = 8'h00;

  always #5 clk = ~clk;

  asram_ctl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(ce_n), .mem_we_n(we_n),
    .mem_oe_n(oe_n), .mem_dq(dq)
  );

  // memory model: drives only when selected for read, commits on rising write strobe
  assign dq = (!ce_n && !oe_n && we_n) ? model[mem_addr[7:0]] : 8'bz;
  always @(posedge we_n) if (!ce_n) model[mem_addr[7:0]] = dq;
  initial for (int i = 0; i < 256; i++) model[i] = 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
  endtask

  task automatic op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                    input bit poke, input logic [16:0] pa, output logic [7:0] rd);
    int lat = 1, wl = 0, ol = 0, bad_d = 0, bad_a = 0, bad_rdy = 0, bad_hold = 0;
    bit prev_wl = 0, hold_seen = 0;
    while (!ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(mem_addr == a && ce_n && we_n && oe_n, "R4 setup cycle", {ce_n, we_n, oe_n}, 3'b111);
    chk(!ready, "R3 ready falls after accept", ready, 0);
    if (poke) begin
      req_valid = 1; req_write = 1; req_addr = pa; req_wdata = 8'hEE;
    end
    while (lat < 40) begin
      @(negedge clk);
      req_valid = 0;
      lat++;
      if (!we_n) begin wl++; if (dq != d) bad_d++; end
      if (!oe_n) ol++;
      if (!ce_n && mem_addr != a) bad_a++;
      if (prev_wl && we_n) begin
        hold_seen = 1;
        if (ce_n || dq != d) bad_hold++;
      end
      prev_wl = !we_n;
      if (ready) bad_rdy++;
      if (done) break;
    end
    chk(bad_a == 0, "R11 address stable", bad_a, 0);
    chk(bad_rdy == 0, "R3 ready low while busy", bad_rdy, 0);
    if (wr) begin
      chk(wl == BW && ol == 0, "R4 write strobe window", wl, BW);
      chk(bad_d == 0, "R5 data driven under write strobe", bad_d, 0);
      chk(hold_seen && bad_hold == 0, "R5 data held after strobe rise", bad_hold, 0);
      chk(lat == BW + 3, "R9 write latency", lat, BW + 3);
      chk(rdata == last_rd, "R8 rdata kept over write", rdata, last_rd);
    end else begin
      chk(ol == BW && wl == 0, "R7 read strobe window", ol, BW);
      chk(lat == BW + 2, "R9 read latency", lat, BW + 2);
      last_rd = rdata;
    end
    rd = rdata;
    chk(done && ce_n && we_n && oe_n && !ready, "R10 done cycle idle strobes",
        {done, ce_n, we_n, oe_n, ready}, 5'b11110);
    @(negedge clk);
    chk(!done && ready, "R8 R10 done one cycle then ready", {done, ready}, 2'b01);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && ready && !done, "R1 reset state",
        {ce_n, we_n, oe_n, ready, done}, 5'b11110);
    rst = 0;
    @(negedge clk);
    chk(ce_n && we_n && oe_n && ready, "R2 standby when idle", {ce_n, we_n, oe_n, ready}, 4'b1111);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][33], VEC[i][32:16], VEC[i][15:8], 1'b0, 17'h0, rd);
      if (!VEC[i][33])
        chk(rd == VEC[i][7:0], "R6 R8 read returns stored word", rd, VEC[i][7:0]);
      chk(ce_n && we_n && oe_n, "R2 standby between requests", {ce_n, we_n, oe_n}, 3'b111);
    end

    // R3: request raised while busy is ignored
    op(1'b1, 17'h00077, 8'h11, 1'b0, 17'h0, rd);
    op(1'b1, 17'h00012, 8'h22, 1'b1, 17'h00077, rd);
    repeat (3) @(negedge clk);
    chk(!done, "R3 no extra done from ignored request", done, 0);
    op(1'b0, 17'h00077, 8'h00, 1'b0, 17'h0, rd);
    chk(rd == 8'h11, "R3 ignored request left memory unchanged", rd, 8'h11);
    op(1'b0, 17'h00012, 8'h00, 1'b0, 17'h0, rd);
    chk(rd == 8'h22, "R6 second write committed", rd, 8'h22);

    // R1: reset in the middle of a write
    while (!ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 17'h00099; req_wdata = 8'h77;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    chk(!we_n, "R4 write strobe low before reset", we_n, 0);
    rst = 1;
    @(negedge clk);
    chk(ce_n && we_n && oe_n && ready && !done, "R1 reset during access",
        {ce_n, we_n, oe_n, ready, done}, 5'b11110);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    op(1'b0, 17'h1FFFF, 8'h00, 1'b0, 17'h0, rd);
    chk(rd == 8'h5A, "R6 data survives reset", rd, 8'h5A);

    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog all requirements actual=%0d expected=%0d", 20000, 0);
    summary();
    $finish;
  end
endmodule